// File: doc/BRIEF.md
# Hitless Reference-Switch Sequencer

This block steers a clock-synthesis loop through a reference changeover without a large phase jump at the output. Once the loop reports lock, the sequencer arms. When lock is later lost (because the reference failed or was reselected), it runs a fixed recovery sequence:

1. Gate off the phase comparator and force the loop filter into its narrow setting.
2. Optionally move the feedback tap by a whole number of oscillator cycles, so that the feedback edge lands nearest the new reference edge.
3. Turn the comparator back on.
4. Count consecutive in-window comparisons until the loop has settled.
5. Hold narrow bandwidth for a fixed settle time, then release it and arm again.

A build-time parameter selects one of three variants:

- no switching support;
- switching support without the feedback-tap step;
- switching support with the feedback-tap step.

Top module: `hs_refswitch_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle (`seq_state`=0), `pd_en`=1, `fb_tap`=0, and `bw_narrow` equals `user_nbw`.
- R2: In idle (`seq_state`=0), `locked`=1 at a rising edge moves the block to armed (`seq_state`=1) at that edge. `locked`=0 in idle leaves it idle.
- R3: In armed, `locked`=0 at an edge starts the sequence. Hold (`seq_state`=2) is entered first, then build (`seq_state`=3). Each lasts exactly one cycle. During both, `pd_en`=0 and the narrow force is active.
- R4: With `HS_MODE`=2 and `pbo_en`=1 at the edge that leaves build, `fb_tap` becomes (`fb_tap` + round(`phase_ofs`)) mod `FB_DIV`. `phase_ofs` is two's complement with `FRAC_W` fraction bits. round(x) = floor(x + 0.5). Otherwise `fb_tap` keeps its value.
- R5: Enable (`seq_state`=4) follows build and lasts one cycle. `pd_en` is 1 from enable onward.
- R6: In qualify (`seq_state`=5), a cycle with `cmp_valid`=1 and `cmp_in_win`=1 adds one to a run count. `cmp_valid`=1 with `cmp_in_win`=0 clears the count. A cycle with `cmp_valid`=0 leaves the count unchanged. The edge that completes `QUAL_N` consecutive in-window comparisons moves the block to settle (`seq_state`=6).
- R7: Settle lasts exactly `TMR_TICKS` cycles. After it, the block is armed (`seq_state`=1) again and the narrow force is released.
- R8: `bw_narrow` is the OR of `user_nbw` and the internal narrow force. The force is active in states 2 to 6.
- R9: With `HS_MODE`=0, the block never leaves idle. `pd_en` stays 1, `fb_tap` stays 0, and `bw_narrow` follows `user_nbw`.
- R10: With `HS_MODE`=1, the sequence runs as in R3 to R7, but `fb_tap` never changes, whatever the value of `pbo_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| locked | input | 1 | Loop lock flag, 1 = locked |
| cmp_valid | input | 1 | One-cycle strobe per phase comparison |
| cmp_in_win | input | 1 | Comparison error lay inside the tight window (qualified by cmp_valid) |
| user_nbw | input | 1 | Narrow-bandwidth request from the user |
| phase_ofs | input | OFS_W | Signed phase offset of new reference, oscillator cycles with FRAC_W fraction bits |
| pbo_en | input | 1 | Allows the feedback-tap step |
| pd_en | output | 1 | Phase comparator enable |
| bw_narrow | output | 1 | Effective narrow-bandwidth select |
| fb_tap | output | TAP_W | Feedback edge offset, 0 to FB_DIV-1 |
| seq_state | output | 3 | Sequencer state code |

## Verification
`seq_state`, `pd_en` and `fb_tap` come straight from registers. Each one therefore shows the result of a rising edge from that edge until the next one. A new tap value first appears in the enable cycle, one edge after build. `bw_narrow` also depends combinationally on `user_nbw`, so it tracks that input within the same cycle.

The bench drives inputs on falling edges and advances its behavioural model on each rising edge. It compares every output a quarter period after that rising edge, against three instances that differ only in variant. Because of this timing, every result is checked in the first cycle in which it is due.

// File: rtl/hs_seq_pkg.sv
// Shared types for the reference-switch sequencer.
// Assumes: state codes are visible at the top port and are stable across variants.
package hs_seq_pkg;
    typedef enum logic [2:0] {
        HS_IDLE   = 3'd0,
        HS_ARMED  = 3'd1,
        HS_HOLD   = 3'd2,
        HS_BUILD  = 3'd3,
        HS_ENABLE = 3'd4,
        HS_QUAL   = 3'd5,
        HS_WAIT   = 3'd6
    } hs_state_e;

    localparam int HS_MODE_NONE = 0;
    localparam int HS_MODE_SW   = 1;
    localparam int HS_MODE_PBO  = 2;
endpackage

// File: rtl/hs_qual_cnt.sv
// Counts consecutive in-window comparisons while enabled.
// Assumes: cmp_in_win is meaningful only together with cmp_valid; clears whenever run is low.
module hs_qual_cnt #(
    parameter int QUAL_N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cmp_valid,
    input  logic cmp_in_win,
    output logic done
);
    localparam int CW = (QUAL_N > 1) ? $clog2(QUAL_N) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUAL_N - 1);

    logic [CW-1:0] cnt_q;
    logic          good;

    // Purpose: decode a good comparison and the run-complete pulse.
    always_comb begin
        good = run && cmp_valid && cmp_in_win;
        done = good && (cnt_q == LAST);
    end

    // Purpose: advance, clear or hold the consecutive-run count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) begin
            cnt_q <= '0;
        end else if (cmp_valid) begin
            cnt_q <= cmp_in_win ? cnt_q + 1'b1 : '0;
        end
    end

    p_qual_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    p_qual_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cmp_valid && !cmp_in_win) |=> (cnt_q == '0));
endmodule

// File: rtl/hs_settle_tmr.sv
// Fixed-length settle timer before wide bandwidth is restored.
// Assumes: TICKS >= 1; counter clears whenever run is low.
module hs_settle_tmr #(
    parameter int TICKS = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

    logic [TW-1:0] cnt_q;

    // Purpose: flag the final tick of the settle window.
    always_comb expire = run && (cnt_q == LAST);

    // Purpose: count ticks while settling.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expire) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    p_tmr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/hs_pbo_tap.sv
// Feedback tap register for phase build-out: adds the rounded offset modulo FB_DIV.
// Assumes: phase_ofs is two's complement with FRAC_W >= 1 fraction bits; FB_DIV >= 2.
module hs_pbo_tap #(
    parameter int FB_DIV = 32,
    parameter int OFS_W  = 10,
    parameter int FRAC_W = 4,
    localparam int TAP_W = $clog2(FB_DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  logic [OFS_W-1:0] phase_ofs,
    output logic [TAP_W-1:0] tap
);
    localparam int SW     = OFS_W + TAP_W + 2;
    localparam int HALF_I = 1 << (FRAC_W - 1);
    localparam logic signed [OFS_W:0]  HALF  = (OFS_W+1)'(HALF_I);
    localparam logic signed [SW-1:0]   DIV_S = SW'(FB_DIV);

    logic [TAP_W-1:0]       tap_q;
    logic signed [OFS_W:0]  ofs_x;
    logic signed [OFS_W:0]  rnd;
    logic signed [SW-1:0]   sum;
    logic signed [SW-1:0]   rem;
    logic signed [SW-1:0]   wrapped;

    // Purpose: round the offset to the nearest cycle and wrap the new tap.
    always_comb begin
        ofs_x   = signed'({phase_ofs[OFS_W-1], phase_ofs}) + HALF;
        rnd     = ofs_x >>> FRAC_W;
        sum     = signed'({{(SW-TAP_W){1'b0}}, tap_q})
                + signed'({{(SW-OFS_W-1){rnd[OFS_W]}}, rnd});
        rem     = sum % DIV_S;
        wrapped = (rem < 0) ? rem + DIV_S : rem;
    end

    // Purpose: load the wrapped tap on the build step only.
    always_ff @(posedge clk) begin
        if (!rst_n)     tap_q <= '0;
        else if (apply) tap_q <= wrapped[TAP_W-1:0];
    end

    assign tap = tap_q;

    p_tap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(tap_q));
    p_tap_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tap_q) < FB_DIV);
endmodule

// File: rtl/hs_refswitch_seq.sv
// Hitless reference-switch sequencer: arm on lock, and on loss of lock run
// hold -> build -> enable -> qualify -> settle, then re-arm.
// Assumes: locked is synchronous to clk; HS_MODE 0 = none, 1 = switch only,
// 2 = switch with feedback build-out.
module hs_refswitch_seq
    import hs_seq_pkg::*;
#(
    parameter int HS_MODE   = 2,
    parameter int FB_DIV    = 32,
    parameter int OFS_W     = 10,
    parameter int FRAC_W    = 4,
    parameter int QUAL_N    = 8,
    parameter int TMR_TICKS = 28,
    localparam int TAP_W    = $clog2(FB_DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked,
    input  logic             cmp_valid,
    input  logic             cmp_in_win,
    input  logic             user_nbw,
    input  logic [OFS_W-1:0] phase_ofs,
    input  logic             pbo_en,
    output logic             pd_en,
    output logic             bw_narrow,
    output logic [TAP_W-1:0] fb_tap,
    output logic [2:0]       seq_state
);
    hs_state_e state_q, state_d;
    logic      qual_done, tmr_done, force_nbw, tap_apply;

    hs_qual_cnt #(.QUAL_N(QUAL_N)) u_qual (
        .clk(clk), .rst_n(rst_n), .run(state_q == HS_QUAL),
        .cmp_valid(cmp_valid), .cmp_in_win(cmp_in_win), .done(qual_done)
    );

    hs_settle_tmr #(.TICKS(TMR_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state_q == HS_WAIT), .expire(tmr_done)
    );

    generate
        if (HS_MODE == HS_MODE_PBO) begin : g_pbo
            // Purpose: build-out only on the build step when enabled.
            always_comb tap_apply = (state_q == HS_BUILD) && pbo_en;
        end else begin : g_nopbo
            always_comb tap_apply = 1'b0;
        end
    endgenerate

    hs_pbo_tap #(.FB_DIV(FB_DIV), .OFS_W(OFS_W), .FRAC_W(FRAC_W)) u_tap (
        .clk(clk), .rst_n(rst_n), .apply(tap_apply),
        .phase_ofs(phase_ofs), .tap(fb_tap)
    );

    // Purpose: next-state decode of the switch sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:   if (HS_MODE != HS_MODE_NONE && locked) state_d = HS_ARMED;
            HS_ARMED:  if (!locked) state_d = HS_HOLD;
            HS_HOLD:   state_d = HS_BUILD;
            HS_BUILD:  state_d = HS_ENABLE;
            HS_ENABLE: state_d = HS_QUAL;
            HS_QUAL:   if (qual_done) state_d = HS_WAIT;
            HS_WAIT:   if (tmr_done) state_d = HS_ARMED;
            default:   state_d = HS_IDLE;
        endcase
    end

    // Purpose: state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: output decode from the current state.
    always_comb begin
        force_nbw = (state_q == HS_HOLD) || (state_q == HS_BUILD) ||
                    (state_q == HS_ENABLE) || (state_q == HS_QUAL) ||
                    (state_q == HS_WAIT);
        pd_en     = !((state_q == HS_HOLD) || (state_q == HS_BUILD));
        bw_narrow = user_nbw | force_nbw;
        seq_state = state_q;
    end

    p_trigger_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_ARMED && !locked) |=> (!pd_en && bw_narrow));
    p_build_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_HOLD) |=> (state_q == HS_BUILD && !pd_en));
    p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_BUILD) |=> (pd_en && state_q == HS_ENABLE));
    p_qual_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_QUAL && qual_done) |=> (state_q == HS_WAIT));
    p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_WAIT && tmr_done) |=> (state_q == HS_ARMED && bw_narrow == user_nbw));

    generate
        if (HS_MODE == HS_MODE_NONE) begin : g_chk_off
            p_stay_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(fb_tap) && pd_en && state_q == HS_IDLE);
        end else begin : g_chk_on
            p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == HS_IDLE && locked) |=> (state_q == HS_ARMED));
        end
        if (HS_MODE == HS_MODE_SW) begin : g_chk_sw
            p_no_tap_r10: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(fb_tap));
        end
    endgenerate
endmodule

// File: tb/hs_refswitch_seq_tb.sv
// Bench: three variants driven in parallel, checked every clock against a behavioural model.
module hs_refswitch_seq_tb_top;
    localparam int CLK_P  = 10;
    localparam int TICKS  = 28;
    localparam int QN     = 8;
    localparam int DIV    = 32;
    localparam int WD_MAX = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic locked = 1'b0, cmp_valid = 1'b0, cmp_in_win = 1'b0, user_nbw = 1'b0, pbo_en = 1'b0;
    logic [9:0] phase_ofs = '0;
    int   ofs_i = 0;

    logic       pd_en [3];
    logic       bw    [3];
    logic [4:0] tap   [3];
    logic [2:0] st    [3];

    int errors = 0, checks = 0, cycles = 0;
    int ms [3], qc [3], tc [3], tp [3];
    bit rst_seen;

    always #(CLK_P/2) clk = ~clk;

    for (genvar g = 0; g < 3; g++) begin : g_dut
        hs_refswitch_seq #(.HS_MODE(g), .FB_DIV(DIV), .OFS_W(10), .FRAC_W(4),
                           .QUAL_N(QN), .TMR_TICKS(TICKS)) dut_i (
            .clk(clk), .rst_n(rst_n), .locked(locked), .cmp_valid(cmp_valid),
            .cmp_in_win(cmp_in_win), .user_nbw(user_nbw), .phase_ofs(phase_ofs),
            .pbo_en(pbo_en), .pd_en(pd_en[g]), .bw_narrow(bw[g]),
            .fb_tap(tap[g]), .seq_state(st[g])
        );
    end

    function automatic string tag(int m, int f);
        if (rst_seen) return "R1";
        if (m == 0) return "R9";
        if (f == 2) return "R8";
        if (f == 3) return (m == 1) ? "R10" : "R4";
        case (ms[m])
            0: return "R2";
            1, 2, 3: return "R3";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(int m, int f, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s mode=%0d field=%0d actual=%0d expected=%0d t=%0t",
                     tag(m, f), m, f, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Model step at the edge, then compare a quarter period later.
    always @(posedge clk) begin
        rst_seen = !rst_n;
        for (int m = 0; m < 3; m++) begin
            if (!rst_n) begin
                ms[m] = 0; qc[m] = 0; tc[m] = 0; tp[m] = 0;
            end else begin
                case (ms[m])
                    0: if (m != 0 && locked) ms[m] = 1;
                    1: if (!locked) ms[m] = 2;
                    2: ms[m] = 3;
                    3: begin
                        if (m == 2 && pbo_en)
                            tp[m] = (((tp[m] + ((ofs_i + 8) >>> 4)) % DIV) + DIV) % DIV;
                        ms[m] = 4;
                    end
                    4: begin ms[m] = 5; qc[m] = 0; end
                    5: if (cmp_valid) begin
                        if (!cmp_in_win) qc[m] = 0;
                        else if (qc[m] == QN - 1) begin ms[m] = 6; qc[m] = 0; tc[m] = 0; end
                        else qc[m]++;
                    end
                    default: if (tc[m] == TICKS - 1) begin ms[m] = 1; tc[m] = 0; end
                             else tc[m]++;
                endcase
            end
        end
        #(CLK_P/4);
        for (int m = 0; m < 3; m++) begin
            check(m, 0, int'(st[m]), ms[m]);
            check(m, 1, int'(pd_en[m]), (ms[m] == 2 || ms[m] == 3) ? 0 : 1);
            check(m, 2, int'(bw[m]), (user_nbw || ms[m] >= 2) ? 1 : 0);
            check(m, 3, int'(tap[m]), tp[m]);
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_MAX) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            report();
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmp(bit v, bit w);
        @(negedge clk);
        cmp_valid = v; cmp_in_win = w;
    endtask

    // One switchover: trigger, qualify with a broken run, then settle.
    task automatic switch_over(int ofs, bit pbo, bit nbw);
        @(negedge clk);
        locked = 1'b0; ofs_i = ofs; phase_ofs = ofs[9:0]; pbo_en = pbo; user_nbw = nbw;
        step(4);
        locked = 1'b1;
        for (int i = 0; i < 5; i++) cmp(1, 1);
        cmp(1, 0);
        cmp(0, 0); cmp(0, 1);
        for (int i = 0; i < 3; i++) cmp(1, 1);
        locked = 1'b0;
        cmp(0, 0);
        for (int i = 0; i < 6; i++) cmp(1, 1);
        cmp(0, 0);
        locked = 1'b1;
        step(TICKS / 2);
        user_nbw = !nbw;
        step(TICKS / 2 + 4);
        user_nbw = 1'b0;
        step(2);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(4);
        locked = 1'b1;
        step(3);
        switch_over(37, 1, 0);
        switch_over(-90, 1, 1);
        switch_over(24, 1, 0);
        switch_over(-8, 1, 0);
        switch_over(200, 0, 0);
        switch_over(-504, 1, 0);
        switch_over(511, 1, 1);
        @(negedge clk) rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(5);
        report();
    end
endmodule